// File: doc/BRIEF.md
# Per-Type Frame Reception Policy Engine

This block sits beside the receive path of a serial storage link and decides, for each arriving frame, whether the link layer answers with a good-receipt or a bad-receipt response. The first dword of every frame carries the frame type in bits [7:0]. The engine looks that type up in a table of 2-bit policy codes. The table is supplied on configuration ports as parallel type and code fields, with a separate fallback code for types that have no entry. The policy then fixes the outcome: accept (answer good unless an error was flagged), reject (always answer bad), or hold for inspection.

In hold mode the engine copies the leading dwords of the frame into slots the host can read by index, raises an interrupt flag and withholds the response. The host reads the slots and gives its accept or reject decision on a one-cycle strobe. The engine answers only once it has both the end of frame and that decision. This lets frame types that the standard protocol handling does not know still be received, under host control. Frame payload storage is not part of the block.

Top module: `fis_rx_policy`

## Requirements
- R1: After reset `resp_valid` and `host_irq` are 0, and `host_rd_data` reads 0 for every slot index.
- R2: The policy code is taken from the lowest-indexed table entry whose type field equals bits [7:0] of the first dword (the beat with `rx_sof`). When no entry matches, `dflt_code` is used.
- R3: With code 00 (accept), `resp_valid` pulses the cycle after the end-of-frame beat. `resp_ok` is 1 only if no beat of the frame had `rx_err` set.
- R4: With code 01 (reject) or code 11 (reserved, handled as reject), the response that follows the end-of-frame beat has `resp_ok` 0.
- R5: With code 10 (hold), the first HOLD_DW dwords of the frame go to slots 0..HOLD_DW-1 in arrival order and are readable through `host_rd_idx`/`host_rd_data`. Later dwords are not stored. Slots the frame did not fill read 0. Slots keep their contents until the next frame starts.
- R6: In hold mode `host_irq` rises the cycle after the beat that fills the last slot, or after the end-of-frame beat if that comes first. It stays high until a decision is taken.
- R7: In hold mode no response is given while `host_irq` is high. The response pulses the cycle after the later of the end-of-frame beat and the decision strobe.
- R8: After a hold-mode decision, `resp_ok` equals `host_dec_accept` ANDed with the absence of `rx_err` on every beat of the frame. A reject always gives a bad response.
- R9: `host_dec_valid` has no effect while `host_irq` is low.
- R10: Each frame gives exactly one response. Beats outside a frame that lack `rx_sof` are ignored. Beats that arrive after a hold-mode frame's end, while it still waits for the host, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received dword valid |
| rx_sof | input | 1 | Beat is the first dword of a frame |
| rx_eof | input | 1 | Beat is the last dword of a frame |
| rx_err | input | 1 | CRC or other error flagged on this beat |
| rx_data | input | DW | Received dword |
| tbl_type | input | NENT*8 | Type field of each table entry, entry i at [i*8 +: 8] |
| tbl_code | input | NENT*2 | Policy code of each table entry, entry i at [i*2 +: 2] |
| dflt_code | input | 2 | Policy code for types with no entry |
| host_dec_valid | input | 1 | One-cycle decision strobe from the host |
| host_dec_accept | input | 1 | Decision: 1 accept, 0 reject |
| host_rd_idx | input | IDXW | Index of the held slot to read |
| host_rd_data | output | DW | Content of the selected held slot |
| host_irq | output | 1 | A held frame waits for the host |
| resp_valid | output | 1 | One-cycle response strobe to the link |
| resp_ok | output | 1 | Response kind: 1 good receipt, 0 bad receipt |

## Verification
If the latched policy code or the error accumulator is wrong, the next response shows it: `resp_ok` has the wrong value one cycle after end of frame. A broken capture counter shows up on `host_rd_data` as soon as the host reads the affected slot, and the same fault moves the rise of `host_irq` by a cycle or more. A lost decision or end-of-frame record leaves the engine stuck. The response then never comes, and every clock after the expected response cycle is a mismatch.

// File: rtl/fis_pol_pkg.sv
package fis_pol_pkg;
   localparam int TYPE_W = 8;

   typedef enum logic [1:0] {
      POL_ACCEPT = 2'b00,
      POL_REJECT = 2'b01,
      POL_HOLD   = 2'b10,
      POL_RSVD   = 2'b11
   } pol_code_e;

   function automatic logic pol_is_hold(input logic [1:0] c);
      return c == POL_HOLD;
   endfunction

   function automatic logic pol_is_accept(input logic [1:0] c);
      return c == POL_ACCEPT;
   endfunction
endpackage

// File: rtl/fis_policy_lut.sv
module fis_policy_lut
   import fis_pol_pkg::*;
#(
   parameter int NENT = 6
) (
   input  logic [TYPE_W-1:0]      type_i,
   input  logic [NENT*TYPE_W-1:0] tbl_type_i,
   input  logic [NENT*2-1:0]      tbl_code_i,
   input  logic [1:0]             dflt_i,
   output logic [1:0]             code_o
);
   logic [NENT-1:0] hit;

   for (genvar g = 0; g < NENT; g++) begin : g_cmp
      assign hit[g] = (tbl_type_i[g*TYPE_W +: TYPE_W] == type_i);
   end

   // lowest index wins: scan downward so the last write is the lowest hit
   always_comb begin
      code_o = dflt_i;
      for (int i = NENT - 1; i >= 0; i--) begin
         if (hit[i]) code_o = tbl_code_i[i*2 +: 2];
      end
   end
endmodule

// File: rtl/fis_hold_regs.sv
module fis_hold_regs #(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   parameter int IDXW  = 2,
   parameter int CNTW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            we_i,
   input  logic [CNTW-1:0] widx_i,
   input  logic [DW-1:0]   wdata_i,
   input  logic [IDXW-1:0] ridx_i,
   output logic [DW-1:0]   rdata_o
);
   logic [DW-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[g] <= '0;
         else if (we_i && widx_i == CNTW'(g))
            slot_q[g] <= wdata_i;
         else if (clr_i)
            slot_q[g] <= '0;
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ridx_i == IDXW'(i)) rdata_o = slot_q[i];
      end
   end
endmodule

// File: rtl/fis_rx_policy.sv
module fis_rx_policy
   import fis_pol_pkg::*;
#(
   parameter int DW      = 32,
   parameter int NENT    = 6,
   parameter int HOLD_DW = 4,
   localparam int IDXW   = (HOLD_DW > 1) ? $clog2(HOLD_DW) : 1,
   localparam int CNTW   = $clog2(HOLD_DW + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rx_valid,
   input  logic                   rx_sof,
   input  logic                   rx_eof,
   input  logic                   rx_err,
   input  logic [DW-1:0]          rx_data,
   input  logic [NENT*TYPE_W-1:0] tbl_type,
   input  logic [NENT*2-1:0]      tbl_code,
   input  logic [1:0]             dflt_code,
   input  logic                   host_dec_valid,
   input  logic                   host_dec_accept,
   input  logic [IDXW-1:0]        host_rd_idx,
   output logic [DW-1:0]          host_rd_data,
   output logic                   host_irq,
   output logic                   resp_valid,
   output logic                   resp_ok
);
   if (DW < TYPE_W) begin : g_bad_dw
      $error("DW must hold the type field");
   end
   if (HOLD_DW < 1) begin : g_bad_hold
      $error("HOLD_DW must be at least 1");
   end
   if (NENT < 1) begin : g_bad_nent
      $error("NENT must be at least 1");
   end

   logic            active_q, eof_seen_q, err_q, dec_q, acc_q, irq_q;
   logic [1:0]      code_q, lut_code, cur_code;
   logic [CNTW-1:0] cap_q, cap_cur;
   logic            beat, start, take, hold, push, raise, eof_now, fin_eof;
   logic            err_cur, dec_now, dec_have, acc_cur, act_cur, fire, ok_d;

   fis_policy_lut #(.NENT(NENT)) lut_i (
      .type_i     (rx_data[TYPE_W-1:0]),
      .tbl_type_i (tbl_type),
      .tbl_code_i (tbl_code),
      .dflt_i     (dflt_code),
      .code_o     (lut_code)
   );

   always_comb begin
      beat     = rx_valid && !eof_seen_q;
      start    = beat && !active_q && rx_sof;
      take     = beat && (active_q || start);
      cur_code = start ? lut_code : code_q;
      hold     = pol_is_hold(cur_code);
      cap_cur  = start ? '0 : cap_q;
      push     = take && hold && (cap_cur < CNTW'(HOLD_DW));
      raise    = push && ((cap_cur == CNTW'(HOLD_DW - 1)) || rx_eof);
      eof_now  = take && rx_eof;
      fin_eof  = eof_seen_q || eof_now;
      err_cur  = take ? ((!start && err_q) || rx_err) : err_q;
      dec_now  = host_dec_valid && irq_q;
      dec_have = dec_q || dec_now;
      acc_cur  = dec_q ? acc_q : host_dec_accept;
      act_cur  = active_q || start;
      fire     = act_cur && fin_eof && (!hold || dec_have);
      ok_d     = hold ? (acc_cur && !err_cur) : (pol_is_accept(cur_code) && !err_cur);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         eof_seen_q <= 1'b0;
         err_q      <= 1'b0;
         dec_q      <= 1'b0;
         acc_q      <= 1'b0;
         irq_q      <= 1'b0;
         code_q     <= POL_ACCEPT;
         cap_q      <= '0;
         resp_valid <= 1'b0;
         resp_ok    <= 1'b0;
      end else begin
         active_q   <= act_cur && !fire;
         eof_seen_q <= fin_eof && !fire;
         err_q      <= err_cur;
         code_q     <= cur_code;
         cap_q      <= push ? cap_cur + 1'b1 : cap_cur;
         dec_q      <= dec_have && !fire;
         if (dec_now) acc_q <= host_dec_accept;
         if (raise)        irq_q <= 1'b1;
         else if (dec_now) irq_q <= 1'b0;
         resp_valid <= fire;
         if (fire) resp_ok <= ok_d;
      end
   end

   fis_hold_regs #(.DW(DW), .DEPTH(HOLD_DW), .IDXW(IDXW), .CNTW(CNTW)) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (start),
      .we_i    (push),
      .widx_i  (cap_cur),
      .wdata_i (rx_data),
      .ridx_i  (host_rd_idx),
      .rdata_o (host_rd_data)
   );

   assign host_irq = irq_q;
endmodule

// File: rtl/fis_rx_policy_chk.sv
module fis_rx_policy_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic rx_eof,
   input logic rx_err,
   input logic host_dec_valid,
   input logic host_dec_accept,
   input logic host_irq,
   input logic resp_valid,
   input logic resp_ok
);
   // R3: an errored closing beat never yields a good response
   a_r3_err_gives_bad: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && $past(rx_valid && rx_eof && rx_err && !host_irq) |-> !resp_ok);

   // R6: the interrupt flag holds until a decision strobe
   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq && !host_dec_valid |=> host_irq);

   // R7: no response while the host has not decided
   a_r7_quiet_while_irq: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> !resp_valid);

   // R7: every response follows a closing beat or a decision
   a_r7_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> ($past(rx_valid && rx_eof) || $past(host_dec_valid && host_irq)));

   // R8: a host reject is answered bad
   a_r8_reject_bad: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && $past(host_dec_valid && host_irq && !host_dec_accept) |-> !resp_ok);
endmodule

bind fis_rx_policy fis_rx_policy_chk chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .rx_valid        (rx_valid),
   .rx_eof          (rx_eof),
   .rx_err          (rx_err),
   .host_dec_valid  (host_dec_valid),
   .host_dec_accept (host_dec_accept),
   .host_irq        (host_irq),
   .resp_valid      (resp_valid),
   .resp_ok         (resp_ok)
);

// File: tb/fis_rx_policy_tb_top.sv
module fis_rx_policy_tb_top;
   localparam int DW   = 32;
   localparam int NENT = 6;
   localparam int HOLD = 4;
   localparam int IDXW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
   logic [DW-1:0] rx_data = '0;
   logic [NENT*8-1:0] tbl_type;
   logic [NENT*2-1:0] tbl_code;
   logic [1:0] dflt_code = 2'b00;
   logic host_dec_valid = 0, host_dec_accept = 0;
   logic [IDXW-1:0] host_rd_idx = '0;
   logic [DW-1:0] host_rd_data;
   logic host_irq, resp_valid, resp_ok;

   always #5 clk = ~clk;

   fis_rx_policy #(.DW(DW), .NENT(NENT), .HOLD_DW(HOLD)) dut_i (.*);

   // table: entry i = {type, code}
   initial begin
      tbl_type = {8'hA1, 8'h58, 8'h34, 8'h46, 8'h34, 8'h27};
      tbl_code = {2'b10, 2'b11, 2'b00, 2'b10, 2'b01, 2'b00};
   end

   // ---------------- reference model ----------------
   int          n_cmp = 0, n_bad = 0;
   string       cur_req = "R1";
   bit          m_act = 0, m_eofs = 0, m_err = 0, m_dec = 0, m_acc = 0, m_irq = 0;
   bit          m_rv = 0, m_ok = 0;
   logic [1:0]  m_code = 0;
   logic [DW-1:0] m_held [HOLD];
   int          m_cnt = 0;
   bit          done = 0;

   initial for (int i = 0; i < HOLD; i++) m_held[i] = '0;

   function automatic logic [1:0] ref_lookup(input logic [7:0] t);
      for (int i = 0; i < NENT; i++)
         if (tbl_type[i*8 +: 8] == t) return tbl_code[i*2 +: 2];
      return dflt_code;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_eofs = 0; m_err = 0; m_dec = 0; m_irq = 0; m_rv = 0; m_ok = 0; m_cnt = 0;
         for (int i = 0; i < HOLD; i++) m_held[i] = '0;
      end else begin
         m_rv = 0;
         if (host_dec_valid && m_irq) begin
            m_dec = 1; m_acc = host_dec_accept; m_irq = 0;
         end
         if (rx_valid && !m_eofs && (m_act || rx_sof)) begin
            if (!m_act) begin
               m_act = 1; m_code = ref_lookup(rx_data[7:0]); m_err = 0; m_dec = 0; m_cnt = 0;
               for (int i = 0; i < HOLD; i++) m_held[i] = '0;
            end
            if (rx_err) m_err = 1;
            if (m_code == 2'b10 && m_cnt < HOLD) begin
               m_held[m_cnt] = rx_data;
               m_cnt++;
               if (m_cnt == HOLD || rx_eof) m_irq = 1;
            end
            if (rx_eof) m_eofs = 1;
         end
         if (m_act && m_eofs) begin
            if (m_code != 2'b10) begin
               m_rv = 1; m_ok = (m_code == 2'b00) && !m_err; m_act = 0; m_eofs = 0;
            end else if (m_dec) begin
               m_rv = 1; m_ok = m_acc && !m_err; m_act = 0; m_eofs = 0; m_dec = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic [DW-1:0] exp_rd;
         exp_rd = (int'(host_rd_idx) < m_cnt || m_code != 2'b10 || 1) ? m_held[host_rd_idx] : '0;
         n_cmp++;
         if (resp_valid !== m_rv || (m_rv && resp_ok !== m_ok) || host_irq !== m_irq ||
             host_rd_data !== exp_rd) begin
            n_bad++;
            $display("FAIL %s t=%0t actual v=%b ok=%b irq=%b rd=%h expected v=%b ok=%b irq=%b rd=%h",
                     cur_req, $time, resp_valid, resp_ok, host_irq, host_rd_data,
                     m_rv, m_ok, m_irq, exp_rd);
         end
      end
   end

   // read index sweeps all slots continuously (R5)
   initial forever begin
      @(negedge clk); #1 host_rd_idx = host_rd_idx + 1'b1;
   end

   // ---------------- stimulus ----------------
   int seed = 1;

   task automatic beat(input logic [DW-1:0] d, input bit s, input bit e, input bit er);
      @(negedge clk); #1;
      rx_valid = 1; rx_sof = s; rx_eof = e; rx_err = er; rx_data = d;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk); #1;
         rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
      end
   endtask

   task automatic part(input logic [7:0] typ, input int from, input int upto,
                       input int n, input int err_at);
      for (int i = from; i <= upto; i++)
         beat({8'hD0 + 8'(i), 8'(seed), 8'h5A, (i == 0) ? typ : 8'(i * 17)},
              i == 0, i == n - 1, i == err_at);
   endtask

   task automatic frame(input logic [7:0] typ, input int n, input int err_at);
      seed++;
      part(typ, 0, n - 1, n, err_at);
      idle(3);
   endtask

   task automatic decide(input bit acc);
      @(negedge clk); #1;
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
      host_dec_valid = 1; host_dec_accept = acc;
      @(negedge clk); #1 host_dec_valid = 0;
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      idle(4);
      cur_req = "R3"; frame(8'h27, 3, -1); frame(8'h27, 4, 2); frame(8'h27, 1, -1);
      frame(8'h27, 1, 0);
      cur_req = "R4"; frame(8'h34, 2, -1); frame(8'h58, 3, -1);
      cur_req = "R2"; frame(8'h99, 2, -1);
      dflt_code = 2'b10; frame(8'h99, 2, -1); decide(1); idle(3);
      dflt_code = 2'b01; frame(8'h99, 3, -1);
      cur_req = "R9"; decide(1); decide(0); idle(2);
      cur_req = "R5"; seed++; part(8'h46, 0, 1, 6, -1);
      cur_req = "R9"; decide(0);
      cur_req = "R6"; part(8'h46, 2, 5, 6, -1); idle(6);
      cur_req = "R7"; decide(1); idle(3);
      cur_req = "R8"; frame(8'hA1, 2, -1); idle(4); decide(0); idle(3);
      frame(8'h46, 5, 4); decide(1); idle(3);
      cur_req = "R7"; seed++; part(8'h46, 0, 4, 8, -1); idle(2); decide(1);
      part(8'h46, 5, 7, 8, -1); idle(4);
      cur_req = "R10"; beat(32'h0000_0027, 0, 1, 0); beat(32'h0000_0027, 0, 0, 0); idle(3);
      seed++; part(8'h46, 0, 2, 3, -1);
      beat(32'h0000_0027, 1, 1, 0); beat(32'hFFFF_FF46, 1, 0, 0); idle(4);
      decide(1); idle(4);
      frame(8'h27, 2, -1);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule